// File: doc/BRIEF.md
# Dual-Clock FIFO with Error Flags

This block is a first-in first-out buffer whose producer and consumer run on two unrelated clocks. Words enter on the write clock and leave on the read clock through a plain inferred memory array. The write side reports full and almost-full. The read side reports empty and almost-empty. Each side also raises a registered error flag when its user tries to move a word the buffer cannot accept or supply.

Both binary pointers are one bit wider than the address. Each pointer crosses to the other domain as a gray code through a two-flop synchroniser. A flag is computed in the domain that needs it, from that domain's own pointer and the synchronised copy of the other pointer. A flag can therefore report a state that is worse than the true one for a few cycles, but never better. One active-low reset input acts at once on both domains. Its release is synchronised separately into each clock domain. It must stay low for at least three cycles of each clock.

Top module: `dcf_fifo`

## Requirements
- R1: On every rising read-clock edge, `rd_err` is loaded with (`rd_en` AND `empty`) as seen at that edge.
- R2: While `rd_en` stays high on an empty buffer, `rd_err` stays high. It returns low on the first read-clock edge at which `rd_en` is low.
- R3: A read attempted while `empty` is high leaves `rdata` unchanged and does not advance the read pointer. The next successful read returns the oldest unread word.
- R4: Driving `arst_n` low immediately forces `empty`=1, `aempty`=1, `full`=0, `afull`=0, `rd_err`=0, `wr_err`=0 and `rdata`=0, without waiting for a clock edge.
- R5: After `arst_n` has been low for at least three cycles of each clock and is released, the buffer holds no words, and newly written words are read back in order.
- R6: Words leave in exactly the order they were accepted, with no loss or duplication. A write is accepted when `wr_en` is high and `full` is low at a write-clock edge. A read is accepted when `rd_en` is high and `empty` is low at a read-clock edge.
- R7: With no reads in flight, `full` rises on the write edge that stores the DEPTH-th word. A write attempted while `full` is high is dropped, and stored data is not disturbed.
- R8: On every rising write-clock edge, `wr_err` is loaded with (`wr_en` AND `full`) as seen at that edge.
- R9: `afull` is high when the occupancy seen by the write side is at least AF_THR. With reads stopped, it tracks the exact number of words written.
- R10: `aempty` is high when the occupancy seen by the read side is at most AE_THR, and `empty` is high when that occupancy is zero. With writes stopped and settled, both track the exact count remaining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Request to store `wdata` |
| wdata | input | DW | Word to store |
| full | output | 1 | No free slot, as seen by the write side |
| afull | output | 1 | Write-side occupancy at or above AF_THR |
| wr_err | output | 1 | Registered: last write edge saw a write while full |
| rd_en | input | 1 | Request to take the next word |
| rdata | output | DW | Last word taken; holds on an empty read |
| empty | output | 1 | No word available, as seen by the read side |
| aempty | output | 1 | Read-side occupancy at or below AE_THR |
| rd_err | output | 1 | Registered: last read edge saw a read while empty |

## Verification
The hardest situation to reach from the ports is a random interleaving that makes both sides push hard against full and empty at the same moment. In that interleaving, each flag lags behind a pointer that is still crossing between the clocks. The stimulus alternates bursty phases in which the writer outruns the reader and phases in which the reader outruns the writer. It runs the two sides on clocks of unrelated period, so that overflow and underflow attempts land while synchronised pointers are stale. Directed fill and drain passes with the opposite side idle pin down the exact flag thresholds and the underflow hold. An asynchronous reset in the middle of traffic shows that the flags drop without a clock edge and that stale words are gone.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
// Package: shared sizing helper for the dual-clock FIFO.
// Assumes depth is a power of two, at least 4.
package dcf_pkg;
    // Pointer width: address bits plus one wrap bit.
    function automatic int unsigned ptr_w(input int unsigned depth);
        return $clog2(depth) + 1;
    endfunction
endpackage

// File: rtl/dcf_rst_sync.sv
`timescale 1ns/1ps
// Reset synchroniser: asserts asynchronously, releases on the second
// edge of clk after arst_n goes high. Assumes arst_n is glitch free.
module dcf_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic stage;

    // Two-flop release chain, cleared at once by the async input.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage   <= 1'b0;
            rst_n_o <= 1'b0;
        end else begin
            stage   <= 1'b1;
            rst_n_o <= stage;
        end
    end
endmodule

// File: rtl/dcf_sync2.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a gray-coded bus. Assumes at most one bit
// of d changes between samples, so any sampled value is a legal code.
module dcf_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Double register into the destination clock domain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
// Write-domain control: owns the write pointer, registers full,
// almost-full and the write-error flag. Assumes rgray_s is the read
// pointer in gray code already synchronised into wclk.
module dcf_wr_side #(
    parameter int PW     = 5,
    parameter int AF_THR = 14
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_s,
    output logic          wr_fire,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          afull,
    output logic          wr_err
);
    localparam int          AW    = PW - 1;
    localparam logic [PW-1:0] CAP = PW'(1 << AW);
    localparam logic [PW-1:0] AFT = PW'(AF_THR);

    logic [PW-1:0] wbin_nx, wgray_nx, rbin_s, occ_nx;

    // Decode the synchronised gray read pointer back to binary.
    always_comb begin
        rbin_s[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        end
    end

    // Next pointer and the occupancy it implies.
    always_comb begin
        wr_fire  = wr_en & ~full;
        wbin_nx  = wbin + PW'(wr_fire);
        wgray_nx = wbin_nx ^ (wbin_nx >> 1);
        occ_nx   = wbin_nx - rbin_s;
    end

    // Register pointer, flags and the overflow indication.
    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            full   <= 1'b0;
            afull  <= 1'b0;
            wr_err <= 1'b0;
        end else begin
            wbin   <= wbin_nx;
            wgray  <= wgray_nx;
            full   <= (occ_nx == CAP);
            afull  <= (occ_nx >= AFT);
            wr_err <= wr_en & full;
        end
    end
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
// Read-domain control: owns the read pointer, registers empty,
// almost-empty and the read-error flag. Assumes wgray_s is the write
// pointer in gray code already synchronised into rclk.
module dcf_rd_side #(
    parameter int PW     = 5,
    parameter int AE_THR = 2
) (
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    output logic          rd_fire,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic          empty,
    output logic          aempty,
    output logic          rd_err
);
    localparam logic [PW-1:0] AET = PW'(AE_THR);

    logic [PW-1:0] rbin_nx, rgray_nx, wbin_s, occ_nx;

    // Decode the synchronised gray write pointer back to binary.
    always_comb begin
        wbin_s[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        end
    end

    // Next pointer and the occupancy left after it.
    always_comb begin
        rd_fire  = rd_en & ~empty;
        rbin_nx  = rbin + PW'(rd_fire);
        rgray_nx = rbin_nx ^ (rbin_nx >> 1);
        occ_nx   = wbin_s - rbin_nx;
    end

    // Register pointer, flags and the underflow indication.
    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin   <= '0;
            rgray  <= '0;
            empty  <= 1'b1;
            aempty <= 1'b1;
            rd_err <= 1'b0;
        end else begin
            rbin   <= rbin_nx;
            rgray  <= rgray_nx;
            empty  <= (occ_nx == '0);
            aempty <= (occ_nx <= AET);
            rd_err <= rd_en & empty;
        end
    end
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO top: inferred storage array, per-domain reset release,
// gray pointer crossing and the two domain controllers.
// Assumes DEPTH is a power of two >= 4, 1 <= AF_THR <= DEPTH and
// 0 <= AE_THR < DEPTH; arst_n held low >= 3 cycles of each clock.
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 16,
    parameter int AE_THR = 2,
    parameter int AF_THR = 14
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          arst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          full,
    output logic          afull,
    output logic          wr_err,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          aempty,
    output logic          rd_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = ptr_w(DEPTH);

    logic          wrst_n, rrst_n;
    logic          wr_fire, rd_fire;
    logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
    logic [DW-1:0] mem [DEPTH];

    dcf_rst_sync u_wrst (.clk(wclk), .arst_n(arst_n), .rst_n_o(wrst_n));
    dcf_rst_sync u_rrst (.clk(rclk), .arst_n(arst_n), .rst_n_o(rrst_n));

    dcf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
    dcf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

    dcf_wr_side #(.PW(PW), .AF_THR(AF_THR)) u_wr (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
        .wr_fire(wr_fire), .wbin(wbin), .wgray(wgray),
        .full(full), .afull(afull), .wr_err(wr_err)
    );

    dcf_rd_side #(.PW(PW), .AE_THR(AE_THR)) u_rd (
        .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
        .rd_fire(rd_fire), .rbin(rbin), .rgray(rgray),
        .empty(empty), .aempty(aempty), .rd_err(rd_err)
    );

    // Storage write port, write clock domain.
    always_ff @(posedge wclk) begin
        if (wr_fire) mem[wbin[AW-1:0]] <= wdata;
    end

    // Registered read port; holds its value when no read fires.
    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) rdata <= '0;
        else if (rd_fire) rdata <= mem[rbin[AW-1:0]];
    end
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the FIFO flags and pointers.
module dcf_fifo_chk #(
    parameter int DW = 8,
    parameter int PW = 5
) (
    input logic          wclk,
    input logic          rclk,
    input logic          wrst_n,
    input logic          rrst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          afull,
    input logic          empty,
    input logic          aempty,
    input logic          wr_err,
    input logic          rd_err,
    input logic [DW-1:0] rdata,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] rbin
);
    a_r1_rderr_set: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && empty) |=> rd_err);
    a_r2_rderr_clear: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!rd_en) |=> !rd_err);
    a_r3_rdata_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && empty) |=> $stable(rdata));
    a_r3_rptr_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && empty) |=> $stable(rbin));
    a_r7_no_overflow: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && full) |=> $stable(wbin));
    a_r8_wrerr_set: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && full) |=> wr_err);
    a_r9_full_implies_afull: assert property (@(posedge wclk) disable iff (!wrst_n)
        full |-> afull);
    a_r10_empty_implies_aempty: assert property (@(posedge rclk) disable iff (!rrst_n)
        empty |-> aempty);
endmodule

bind dcf_fifo dcf_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
    .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
    .wr_en(wr_en), .rd_en(rd_en), .full(full), .afull(afull),
    .empty(empty), .aempty(aempty), .wr_err(wr_err), .rd_err(rd_err),
    .rdata(rdata), .wbin(wbin), .rbin(rbin)
);

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/1ps
module dcf_fifo_tb;
    localparam int DW = 8, DEPTH = 16, AE_THR = 2, AF_THR = 14;

    logic wclk = 1'b0, rclk = 1'b0, arst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic full, afull, wr_err, empty, aempty, rd_err;
    logic [DW-1:0] rdata;

    int total = 0, bad = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] last = '0;
    bit   mon_on = 1'b0;
    bit   pr_rd, pr_emp, pr_rv, pw_wr, pw_full, pw_v;

    dcf_fifo #(.DW(DW), .DEPTH(DEPTH), .AE_THR(AE_THR), .AF_THR(AF_THR)) u_dut (
        .wclk(wclk), .rclk(rclk), .arst_n(arst_n), .wr_en(wr_en), .wdata(wdata),
        .full(full), .afull(afull), .wr_err(wr_err), .rd_en(rd_en), .rdata(rdata),
        .empty(empty), .aempty(aempty), .rd_err(rd_err)
    );

    always #4 wclk = ~wclk;   // 125 MHz write clock
    always #5 rclk = ~rclk;   // unrelated read clock

    function automatic bit exp_af(input int n); return n >= AF_THR; endfunction
    function automatic bit exp_ae(input int n); return n <= AE_THR; endfunction
    function automatic bit exp_full(input int n); return n == DEPTH; endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Sample read-side inputs and flag as they stand at the edge.
    always @(posedge rclk) begin
        pr_rv = mon_on && arst_n; pr_rd = rd_en; pr_emp = empty;
    end
    // Check read-side results half a cycle later (R1, R3, R6).
    always @(negedge rclk) begin
        if (pr_rv) begin
            chk("R1 rd_err", rd_err, pr_rd & pr_emp);
            if (pr_rd && !pr_emp) begin
                if (q.size() == 0) chk("R6 read with model empty", 1, 0);
                else begin
                    last = q.pop_front();
                    chk("R6 order", rdata, last);
                end
            end else if (pr_rd) chk("R3 rdata hold", rdata, last);
        end
    end
    // Sample and check the write-error flag (R8).
    always @(posedge wclk) begin
        pw_v = mon_on && arst_n; pw_wr = wr_en; pw_full = full;
    end
    always @(negedge wclk) begin
        if (pw_v) chk("R8 wr_err", wr_err, pw_wr & pw_full);
    end

    task automatic do_reset();
        mon_on = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0;
        arst_n = 1'b0;
        #1;
        chk("R4 empty", empty, 1); chk("R4 aempty", aempty, 1);
        chk("R4 full", full, 0);   chk("R4 afull", afull, 0);
        chk("R4 rd_err", rd_err, 0); chk("R4 wr_err", wr_err, 0);
        chk("R4 rdata", rdata, 0);
        q.delete(); last = '0;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        arst_n = 1'b1;
        repeat (4) @(negedge rclk);
        mon_on = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge wclk);
        do_reset();

        // Directed fill with reads idle: R7 and R9 exact thresholds.
        for (int k = 0; k <= DEPTH + 2; k++) begin
            @(negedge wclk);
            chk("R7 full", full, exp_full(k > DEPTH ? DEPTH : k));
            chk("R9 afull", afull, exp_af(k > DEPTH ? DEPTH : k));
            if (k < DEPTH + 2) begin
                wr_en = 1'b1; wdata = DW'($urandom);
                if (!full) q.push_back(wdata);
            end else wr_en = 1'b0;
        end
        repeat (6) @(negedge rclk);
        chk("R10 empty after fill", empty, 0);
        chk("R10 aempty after fill", aempty, 0);

        // Directed drain into underflow: R10, R3, R2.
        for (int k = 0; k <= DEPTH + 3; k++) begin
            @(negedge rclk);
            chk("R10 empty", empty, (k >= DEPTH));
            chk("R10 aempty", aempty, exp_ae(DEPTH - (k > DEPTH ? DEPTH : k)));
            rd_en = (k < DEPTH + 3);
        end
        chk("R2 rd_err held", rd_err, 1);
        @(negedge rclk);
        chk("R2 rd_err falls", rd_err, 0);
        repeat (6) @(negedge wclk);
        chk("R7 full cleared", full, 0);

        // Random concurrent traffic with alternating pressure: R6, R7, R1.
        fork
            begin
                for (int i = 0; i < 1500; i++) begin
                    @(negedge wclk);
                    wr_en = ($urandom % 100) < (((i / 250) % 2) ? 85 : 30);
                    wdata = DW'($urandom);
                    if (wr_en && !full) q.push_back(wdata);
                end
                @(negedge wclk); wr_en = 1'b0;
            end
            begin
                for (int i = 0; i < 1200; i++) begin
                    @(negedge rclk);
                    rd_en = ($urandom % 100) < (((i / 200) % 2) ? 35 : 90);
                end
                @(negedge rclk); rd_en = 1'b0;
            end
        join
        repeat (8) @(negedge rclk);
        rd_en = 1'b1;
        repeat (DEPTH + 8) @(negedge rclk);
        rd_en = 1'b0;
        @(negedge rclk);
        chk("R6 all words delivered", q.size(), 0);
        chk("R10 empty at end", empty, 1);

        // Reset in the middle of traffic: R4 and R5.
        for (int i = 0; i < 5; i++) begin
            @(negedge wclk); wr_en = 1'b1; wdata = DW'(8'hA0 + i); q.push_back(wdata);
        end
        @(negedge wclk); wr_en = 1'b0;
        #3;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge wclk); wr_en = 1'b1; wdata = DW'(8'h50 + i); q.push_back(wdata);
        end
        @(negedge wclk); wr_en = 1'b0;
        repeat (6) @(negedge rclk);
        chk("R5 empty after new writes", empty, 0);
        chk("R5 aempty with three words", aempty, exp_ae(3));
        rd_en = 1'b1;
        @(negedge rclk);
        chk("R5 first word after reset", rdata, 8'h50);
        repeat (4) @(negedge rclk);
        rd_en = 1'b0;
        @(negedge rclk);
        chk("R5 queue drained", q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1600000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule